// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block gathers the interrupt sources of a two-wire serial bus controller into one request line. It offers three register views over the same set of sources: a raw status word, a mask word, and a masked status word that is raw ANDed with mask. The interrupt output is the registered OR of the masked status bits.

There are two kinds of source. Six FIFO level flags are sampled every cycle, so their raw bits simply follow the inputs. Nine event sources arrive as one-cycle pulses. Each event sets a sticky raw bit, and software clears it by writing 1 to the matching bit of the clear register. Software reaches the registers through a write strobe, a 2-bit register select and a combinational read data bus.

Top module: `irq_status_unit`

## Requirements
- R1: The raw status bit positions are as follows. Level bits: tx empty 0, tx nearly empty 1, tx full 2, rx empty 4, rx nearly full 5, rx full 6, driven by `level_i[0..5]` in that order. Event bits: tx overrun 3, read-from-slave request 16, read-from-slave empty 17, write-to-slave request 18, master done 19, slave done 20, arbitration lost 24, bus error 25, master done without stop 28, driven by `event_i[0..8]` in that order. Every other raw bit reads 0.
- R2: A level bit in the raw view equals its input as sampled at the previous rising clock edge. Clear writes never change a level bit.
- R3: An event pulse sets its raw bit from the next edge on. The bit stays set until a write to the clear register (select 3) has a 1 at that bit position.
- R4: If an event pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R5: A clear write only acts on bits that are inside 0x131F007F and are event bits. All other positions in the clear word have no effect.
- R6: A write with select 1 loads the mask word, and the mask word reads back on select 1. Bits 31:29 of the mask always read 0. Select 3 reads 0.
- R7: Select 0 reads the raw word and select 2 reads raw AND mask. Writes with select 0 or select 2 are ignored.
- R8: `irq_o` is high in a cycle exactly when the masked status word was nonzero in the cycle before.
- R9: After reset, the mask word, all event bits and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| level_i | input | 6 | FIFO level flags |
| event_i | input | 9 | One-cycle event pulses |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 raw, 1 mask, 2 masked, 3 clear |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected register |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the event inputs are true single-cycle pulses sampled on the clock. They also assume that the level inputs and register strobes only change away from the rising edge. The bench drives every input on the falling edge and holds it for a whole cycle. In random mode it keeps event pulses sparse, so that both the sticky behaviour and the set/clear collisions are exercised. It also aims random clear words across the whole 32-bit range, including level bits and reserved positions.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_LVL = 6;
  localparam int NUM_EVT = 9;
  localparam int ADDR_W  = 2;

  localparam logic [DATA_W-1:0] CLR_ALLOWED = 32'h131F_007F;
  localparam logic [DATA_W-1:0] RSVD_BITS   = 32'hE000_0000;

  typedef enum logic [ADDR_W-1:0] {
    REG_RAW    = 2'd0,
    REG_MASK   = 2'd1,
    REG_MASKED = 2'd2,
    REG_CLEAR  = 2'd3
  } isu_reg_e;

  // level source i -> status bit position
  function automatic int lvl_pos(input int i);
    return (i < 3) ? i : i + 1;
  endfunction

  // event source i -> status bit position
  function automatic int evt_pos(input int i);
    int p;
    case (i)
      0:       p = 3;
      1:       p = 16;
      2:       p = 17;
      3:       p = 18;
      4:       p = 19;
      5:       p = 20;
      6:       p = 24;
      7:       p = 25;
      default: p = 28;
    endcase
    return p;
  endfunction

  function automatic logic [DATA_W-1:0] lvl_map();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_LVL; i++) m[lvl_pos(i)] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] evt_map();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_EVT; i++) m[evt_pos(i)] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] LVL_MAP = lvl_map();
  localparam logic [DATA_W-1:0] EVT_MAP = evt_map();
endpackage

// File: rtl/isu_level_sampler.sv
module isu_level_sampler
  import isu_pkg::*;
#(
  parameter int N = NUM_LVL,
  parameter int W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] level_i,
  output logic [W-1:0] lvl_vec_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= level_i;
  end

  always_comb begin
    lvl_vec_o = '0;
    for (int i = 0; i < N; i++) lvl_vec_o[lvl_pos(i)] = lvl_q[i];
  end
endmodule

// File: rtl/isu_event_bank.sv
module isu_event_bank #(
  parameter int N = isu_pkg::NUM_EVT
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] evt_o
);
  for (genvar g = 0; g < N; g++) begin : g_evt
    logic q;
    // set dominates a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;
      else if (clr_i[g]) q <= 1'b0;
    end
    assign evt_o[g] = q;
  end
endmodule

// File: rtl/isu_mask_reg.sv
module isu_mask_reg
  import isu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (we_i) mask_q <= wdata_i & ~RSVD_BITS;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import isu_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LVL-1:0] level_i,
  input  logic [NUM_EVT-1:0] event_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  logic [DATA_W-1:0]  lvl_vec_w;
  logic [DATA_W-1:0]  evt_vec_w;
  logic [DATA_W-1:0]  raw_w;
  logic [DATA_W-1:0]  mask_w;
  logic [DATA_W-1:0]  masked_w;
  logic [NUM_EVT-1:0] evt_q_w;
  logic [NUM_EVT-1:0] clr_evt_w;
  logic               mask_we_w;
  logic               clr_stb_w;
  logic               irq_q;

  assign mask_we_w = wr_en_i && (addr_i == REG_MASK);
  assign clr_stb_w = wr_en_i && (addr_i == REG_CLEAR);

  always_comb begin
    for (int i = 0; i < NUM_EVT; i++)
      clr_evt_w[i] = clr_stb_w & wdata_i[evt_pos(i)] & CLR_ALLOWED[evt_pos(i)];
  end

  isu_level_sampler #(.N(NUM_LVL), .W(DATA_W)) u_lvl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (level_i),
    .lvl_vec_o (lvl_vec_w)
  );

  isu_event_bank #(.N(NUM_EVT)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (event_i),
    .clr_i  (clr_evt_w),
    .evt_o  (evt_q_w)
  );

  isu_mask_reg #(.W(DATA_W)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mask_we_w),
    .wdata_i (wdata_i),
    .mask_o  (mask_w)
  );

  always_comb begin
    evt_vec_w = '0;
    for (int i = 0; i < NUM_EVT; i++) evt_vec_w[evt_pos(i)] = evt_q_w[i];
  end

  assign raw_w    = lvl_vec_w | evt_vec_w;
  assign masked_w = raw_w & mask_w;

  always_comb begin
    unique case (isu_reg_e'(addr_i))
      REG_RAW:    rdata_o = raw_w;
      REG_MASK:   rdata_o = mask_w;
      REG_MASKED: rdata_o = masked_w;
      default:    rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |masked_w;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk
  import isu_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_LVL-1:0] level_i,
  input logic [NUM_EVT-1:0] event_i,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  raw_i,
  input logic [DATA_W-1:0]  mask_i,
  input logic               irq_i
);
  logic [DATA_W-1:0] lvl_exp;
  logic [DATA_W-1:0] evt_exp;
  logic [DATA_W-1:0] clr_word;

  always_comb begin
    lvl_exp = '0;
    evt_exp = '0;
    for (int i = 0; i < NUM_LVL; i++) lvl_exp[lvl_pos(i)] = level_i[i];
    for (int i = 0; i < NUM_EVT; i++) evt_exp[evt_pos(i)] = event_i[i];
  end

  assign clr_word = (wr_en_i && addr_i == REG_CLEAR) ? wdata_i : '0;

  p_unmapped_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i & ~(LVL_MAP | EVT_MAP)) == '0);

  p_level_track_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((raw_i & LVL_MAP) == $past(lvl_exp)));

  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((raw_i & $past(raw_i & EVT_MAP & ~clr_word)) == $past(raw_i & EVT_MAP & ~clr_word)));

  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((raw_i & $past(evt_exp)) == $past(evt_exp)));

  p_mask_rsvd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i & RSVD_BITS) == '0);

  p_irq_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (irq_i == |($past(raw_i & mask_i))));
endmodule

bind irq_status_unit irq_status_unit_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .level_i (level_i),
  .event_i (event_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .raw_i   (raw_w),
  .mask_i  (mask_w),
  .irq_i   (irq_o)
);

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  level = '0;
  logic [8:0]  event_p = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model
  logic [31:0] m_lvl = '0;
  logic [31:0] m_evt = '0;
  logic [31:0] m_mask = '0;
  logic        m_irq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_unit u_irq_status_unit (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .level_i (level),
    .event_i (event_p),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  function automatic logic [31:0] spread_lvl(input logic [5:0] l);
    return {25'd0, l[5:3], 1'b0, l[2:0]};
  endfunction

  function automatic logic [31:0] spread_evt(input logic [8:0] e);
    logic [31:0] v;
    v = '0;
    v[3]     = e[0];
    v[20:16] = e[5:1];
    v[24]    = e[6];
    v[25]    = e[7];
    v[28]    = e[8];
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // read all views at the current (negedge) time
  task automatic check_all(input string tag);
    logic [31:0] raw_e;
    raw_e = m_lvl | m_evt;
    addr = 2'd0; #1 check({tag, " R1 raw"}, rdata, raw_e);
    addr = 2'd1; #1 check({tag, " R6 mask"}, rdata, m_mask);
    addr = 2'd2; #1 check({tag, " R7 masked"}, rdata, raw_e & m_mask);
    addr = 2'd3; #1 check({tag, " R6 clear reads zero"}, rdata, 32'd0);
    check({tag, " R8 irq"}, {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic step(input logic [5:0] l, input logic [8:0] e, input logic we,
                      input logic [1:0] a, input logic [31:0] d, input string tag);
    logic [31:0] clrv;
    level = l; event_p = e; wr_en = we; addr = a; wdata = d;
    @(posedge clk);
    m_irq = |((m_lvl | m_evt) & m_mask);
    m_lvl = spread_lvl(l);
    clrv  = (we && a == 2'd3) ? (d & 32'h131F_007F) : 32'd0;
    m_evt = (m_evt & ~clrv) | spread_evt(e);
    if (we && a == 2'd1) m_mask = d & 32'h1FFF_FFFF;
    @(negedge clk);
    event_p = '0; wr_en = 1'b0;
    check_all(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R9 reset");

    // mask readback with reserved bits
    step(6'd0, 9'd0, 1'b1, 2'd1, 32'hFFFF_FFFF, "R6 mask all ones");
    check("R6 rsvd", m_mask, 32'h1FFF_FFFF);
    // levels ignore clear
    step(6'h3F, 9'd0, 1'b1, 2'd3, 32'hFFFF_FFFF, "R2 level vs clear");
    step(6'h3F, 9'd0, 1'b0, 2'd0, 32'd0, "R2 level hold");
    step(6'h00, 9'd0, 1'b0, 2'd0, 32'd0, "R2 level drop");
    // event sticky, out-of-set clear ignored
    step(6'd0, 9'h1FF, 1'b0, 2'd0, 32'd0, "R3 all events");
    step(6'd0, 9'd0, 1'b1, 2'd3, ~32'h131F_007F, "R5 clear outside set");
    step(6'd0, 9'd0, 1'b1, 2'd3, 32'h0000_0077, "R5 clear level bits");
    step(6'd0, 9'd0, 1'b1, 2'd0, 32'hFFFF_FFFF, "R7 write raw ignored");
    step(6'd0, 9'd0, 1'b1, 2'd2, 32'hFFFF_FFFF, "R7 write masked ignored");
    // set wins over same-cycle clear
    step(6'd0, 9'h100, 1'b1, 2'd3, 32'h1000_0000, "R4 set vs clear");
    check("R4 bit28 kept", m_evt & 32'h1000_0000, 32'h1000_0000);
    step(6'd0, 9'd0, 1'b1, 2'd3, 32'hFFFF_FFFF, "R3 clear all");
    check("R3 all cleared", m_evt, 32'd0);
    // irq gating by mask
    step(6'd0, 9'd0, 1'b1, 2'd1, 32'h0000_0008, "R8 mask overrun only");
    step(6'h01, 9'd0, 1'b0, 2'd0, 32'd0, "R8 unmasked level");
    step(6'h00, 9'h001, 1'b0, 2'd0, 32'd0, "R8 masked event");
    step(6'h00, 9'd0, 1'b0, 2'd0, 32'd0, "R8 irq high");
    step(6'h00, 9'd0, 1'b1, 2'd3, 32'h0000_0008, "R3 clear overrun");
    step(6'h00, 9'd0, 1'b0, 2'd0, 32'd0, "R8 irq low");

    for (int k = 0; k < 600; k++) begin
      logic [8:0]  e;
      logic [31:0] d;
      e = (($urandom % 4) == 0) ? 9'($urandom) & 9'($urandom) : 9'd0;
      d = (($urandom % 3) == 0) ? 32'($urandom) & 32'h131F_0008 : 32'($urandom);
      step(6'($urandom), e, (($urandom % 3) == 0), 2'($urandom), d, "random");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule